// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received Ethernet frames from a byte stream into system memory by walking a circular list of descriptors that software prepares. Each descriptor is four 32-bit words: a status/length word, the address of a data buffer, a spare word, and the address of the following descriptor. The engine reads the status word and proceeds only when bit 31 (the ownership flag) says the hardware owns the descriptor. It then fetches the buffer and next-descriptor addresses, packs incoming bytes into words and stores them in the buffer. Finally it writes back a status word that carries the length and the error classes, with the ownership bits cleared so that software owns the descriptor again.

After each writeback the engine follows the next pointer and fetches the next status word straight away. When it finds a descriptor owned by software, or when the memory side reports a bus error, it raises an interrupt flag and stops. It stays stopped until software writes the start register again. Software programs the ring through four word registers: the ring start address, a read-only view of the current descriptor address, the start trigger, and an interrupt status register whose bits are cleared by writing 1.

The memory side is a single request/acknowledge word interface. The frame side is a byte stream with an end-of-frame marker and two error flags that are valid with the last byte.

Top module: `rxdma_ring`

## Requirements
- R1: After reset the current descriptor address reads 0, `irq` is 0, the status register reads 0, and both `mem_req` and `rx_ready` are 0.
- R2: A write to offset 0x00 while the engine is stopped sets the ring start and also loads the current descriptor address. The current address is read back at offset 0x04 in the next cycle.
- R3: Writing a word with bit 0 set to offset 0x08 while the engine is stopped starts it. Its first memory access is a read of the status word at the current descriptor address.
- R4: If the status word has bit 31 clear, the engine sets status bit 10 and drives `irq` high. It then issues no further memory request and does not assert `rx_ready` until it is triggered again.
- R5: Frame byte k is stored in byte lane k mod 4 (lane 0 = bits 7:0) of the word at buffer address + 4*floor(k/4). A final partial word has zeros in its unused lanes.
- R6: Every status writeback goes to the descriptor's first word. It has bits 31:30 at 0 and the stored length in bits 15:0, and it sets bit 20 only when none of the error bits 17, 19, 21 and 22 is set.
- R7: A CRC error flag on the last byte sets status bit 17. An alignment error flag on the last byte sets bit 21.
- R8: For a frame longer than BUF_BYTES, only the first BUF_BYTES bytes are written. The remaining bytes are still accepted but dropped, the length field equals BUF_BYTES, and bit 19 is set.
- R9: A frame whose stored length is below MIN_LEN sets status bit 22.
- R10: After a writeback the current descriptor address becomes the next pointer read from word 3 (offset +12), and the next access is a status read at that address.
- R11: A memory acknowledge with `mem_err` high sets status bit 11 and raises `irq`. The engine stops with the current address unchanged and makes no further requests.
- R12: Writing 1 to bit 10 or bit 11 of offset 0x0C clears that bit. `irq` is high exactly while either bit is set.
- R13: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable until `mem_ack`. `rx_ready` is high only while no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt: any status bit set |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Bus error, valid with mem_ack |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Last byte of frame |
| rx_crc_err | input | 1 | CRC error, valid with rx_last |
| rx_align_err | input | 1 | Alignment error, valid with rx_last |
| rx_ready | output | 1 | Engine accepts a byte this cycle |

## Verification
A trigger becomes visible at the first rising edge after the register write, and the status read request is on `mem_addr` in the cycle that follows. A register write takes effect on reads one cycle later. `irq` rises one cycle after the acknowledge that ends a stopped walk. The scoreboard holds the data and status writes in the order the engine must issue them, and the memory model compares each write at the falling edge where it serves the request, so each write is checked in the cycle it is due. Stop conditions are confirmed by watching `mem_req` and `rx_ready` for a window of cycles after `irq` rises, and register effects are sampled at falling edges.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_BUF,
        ST_RD_NEXT,
        ST_RECV,
        ST_WR_DATA,
        ST_WR_STAT
    } rxd_state_e;

    // descriptor status word bit positions (software decodes these)
    localparam int BIT_OWN   = 31;
    localparam int BIT_RUNT  = 22;
    localparam int BIT_ALIGN = 21;
    localparam int BIT_GOOD  = 20;
    localparam int BIT_LONG  = 19;
    localparam int BIT_CRC   = 17;

    // interrupt status bit positions
    localparam int IRQ_UNAVAIL = 10;
    localparam int IRQ_BUSERR  = 11;

    // register offsets
    localparam logic [7:0] OFF_BASE = 8'h00;
    localparam logic [7:0] OFF_CUR  = 8'h04;
    localparam logic [7:0] OFF_KICK = 8'h08;
    localparam logic [7:0] OFF_IRQ  = 8'h0C;

    function automatic logic [31:0] make_status(input logic [15:0] len,
                                                input logic crc,
                                                input logic align,
                                                input logic long_f,
                                                input logic runt);
        logic [31:0] s;
        s = 32'd0;
        s[15:0]      = len;
        s[BIT_CRC]   = crc;
        s[BIT_LONG]  = long_f;
        s[BIT_ALIGN] = align;
        s[BIT_RUNT]  = runt;
        s[BIT_GOOD]  = !(crc || long_f || align || runt);
        return s;
    endfunction

endpackage

// File: rtl/rxd_csr.sv
module rxd_csr
    import rxd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] cur_addr,
    input  logic        set_unavail,
    input  logic        set_berr,
    output logic        kick,
    output logic        load_cur,
    output logic        irq
);

    typedef struct packed {
        logic [31:0] base;
        logic        unav;
        logic        berr;
    } csr_t;

    csr_t q, d;
    logic w1c;

    always_comb begin
        d        = q;
        w1c      = reg_we && (reg_addr == OFF_IRQ);
        kick     = reg_we && (reg_addr == OFF_KICK) && reg_wdata[0];
        load_cur = reg_we && (reg_addr == OFF_BASE);
        if (load_cur) begin
            d.base = reg_wdata;
        end
        d.unav = (q.unav && !(w1c && reg_wdata[IRQ_UNAVAIL])) || set_unavail;
        d.berr = (q.berr && !(w1c && reg_wdata[IRQ_BUSERR])) || set_berr;

        reg_rdata = 32'd0;
        case (reg_addr)
            OFF_BASE: reg_rdata = q.base;
            OFF_CUR:  reg_rdata = cur_addr;
            OFF_IRQ: begin
                reg_rdata[IRQ_UNAVAIL] = q.unav;
                reg_rdata[IRQ_BUSERR]  = q.berr;
            end
            default:  reg_rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq = q.unav || q.berr;

    // a set event wins over a simultaneous clear
    assert_unavail_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_unavail |=> irq);
    assert_berr_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_berr |=> irq);
    assert_w1c_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && reg_wdata[IRQ_UNAVAIL] && reg_wdata[IRQ_BUSERR] && !set_unavail && !set_berr)
        |=> !irq);

endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
    parameter int BUF_BYTES = 1536,
    localparam int CW = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [7:0]    byte_in,
    input  logic          wclr,
    output logic [31:0]   word,
    output logic [CW-1:0] count,
    output logic          over
);

    localparam logic [CW-1:0] CAP = CW'(BUF_BYTES);

    typedef struct packed {
        logic [31:0]   word;
        logic [CW-1:0] count;
        logic          over;
    } pk_t;

    pk_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else begin
            if (wclr) begin
                d.word = 32'd0;
            end
            if (push) begin
                if (q.count < CAP) begin
                    d.word[8*q.count[1:0] +: 8] = byte_in;
                    d.count = q.count + CW'(1);
                end else begin
                    d.over = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word  = q.word;
    assign count = q.count;
    assign over  = q.over;

    assert_count_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CAP);
    assert_over_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.over |-> (q.count == CAP));

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int BUF_BYTES = 1536,
    parameter int MIN_LEN   = 64,
    localparam int CW = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick,
    input  logic          load_cur,
    input  logic [31:0]   load_val,
    output logic [31:0]   cur_addr,
    output logic          set_unavail,
    output logic          set_berr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic          rx_valid,
    input  logic          rx_last,
    input  logic          rx_crc_err,
    input  logic          rx_align_err,
    output logic          rx_ready,
    output logic          pk_clear,
    output logic          pk_push,
    output logic          pk_wclr,
    input  logic [31:0]   pk_word,
    input  logic [CW-1:0] pk_count,
    input  logic          pk_over
);

    localparam logic [CW-1:0] CAP  = CW'(BUF_BYTES);
    localparam logic [CW-1:0] MINV = (MIN_LEN > BUF_BYTES) ? CAP : CW'(MIN_LEN);

    typedef struct packed {
        rxd_state_e  st;
        logic [31:0] cur;
        logic [31:0] buf_a;
        logic [31:0] nxt;
        logic        crc;
        logic        align;
        logic        last;
    } eng_t;

    eng_t q, d;
    logic [31:0] cnt32;
    logic        stored;

    always_comb begin
        d           = q;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = 32'd0;
        mem_wdata   = 32'd0;
        rx_ready    = 1'b0;
        pk_clear    = 1'b0;
        pk_push     = 1'b0;
        pk_wclr     = 1'b0;
        set_unavail = 1'b0;
        set_berr    = 1'b0;
        cnt32       = 32'(pk_count);
        stored      = pk_count < CAP;

        case (q.st)
            ST_IDLE: begin
                if (load_cur) d.cur = load_val;
                if (kick)     d.st  = ST_RD_STAT;
            end
            ST_RD_STAT: begin
                mem_req  = 1'b1;
                mem_addr = q.cur;
                if (mem_ack) begin
                    if (!mem_rdata[BIT_OWN]) begin
                        set_unavail = 1'b1;
                        d.st        = ST_IDLE;
                    end else begin
                        d.st = ST_RD_BUF;
                    end
                end
            end
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + 32'd4;
                if (mem_ack) begin
                    d.buf_a = mem_rdata;
                    d.st    = ST_RD_NEXT;
                end
            end
            ST_RD_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + 32'd12;
                if (mem_ack) begin
                    d.nxt    = mem_rdata;
                    d.crc    = 1'b0;
                    d.align  = 1'b0;
                    d.last   = 1'b0;
                    pk_clear = 1'b1;
                    d.st     = ST_RECV;
                end
            end
            ST_RECV: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    pk_push = 1'b1;
                    if (rx_last) begin
                        d.crc   = rx_crc_err;
                        d.align = rx_align_err;
                        d.last  = 1'b1;
                    end
                    if (stored && (pk_count[1:0] == 2'd3 || rx_last)) begin
                        d.st = ST_WR_DATA;
                    end else if (rx_last) begin
                        d.st = ST_WR_STAT;
                    end
                end
            end
            ST_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.buf_a + ((cnt32 - 32'd1) & ~32'd3);
                mem_wdata = pk_word;
                if (mem_ack) begin
                    pk_wclr = 1'b1;
                    d.st    = q.last ? ST_WR_STAT : ST_RECV;
                end
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cur;
                mem_wdata = make_status(cnt32[15:0], q.crc, q.align, pk_over,
                                        pk_count < MINV);
                if (mem_ack) begin
                    d.cur = q.nxt;
                    d.st  = ST_RD_STAT;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // a bus error on any access abandons the walk
        if (mem_req && mem_ack && mem_err) begin
            d           = q;
            d.st        = ST_IDLE;
            set_berr    = 1'b1;
            set_unavail = 1'b0;
            pk_clear    = 1'b0;
            pk_wclr     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cur_addr = q.cur;

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
    assert_ready_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !mem_req);
    assert_stop_after_unavail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_unavail |=> (!mem_req && !rx_ready));
    assert_stop_after_berr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_berr |=> (!mem_req && $stable(cur_addr)));
    assert_owner_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == q.cur) |-> (mem_wdata[31:30] == 2'b00));
    assert_follow_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR_STAT && mem_ack && !mem_err) |=> (cur_addr == $past(q.nxt)));

endmodule

// File: rtl/rxdma_ring.sv
module rxdma_ring
    import rxd_pkg::*;
#(
    parameter int BUF_BYTES = 1536,
    parameter int MIN_LEN   = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_crc_err,
    input  logic        rx_align_err,
    output logic        rx_ready
);

    localparam int CW = $clog2(BUF_BYTES + 1);

    logic [31:0]   cur_addr;
    logic          kick, load_cur, set_unavail, set_berr;
    logic          pk_clear, pk_push, pk_wclr, pk_over;
    logic [31:0]   pk_word;
    logic [CW-1:0] pk_count;

    rxd_csr u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cur_addr    (cur_addr),
        .set_unavail (set_unavail),
        .set_berr    (set_berr),
        .kick        (kick),
        .load_cur    (load_cur),
        .irq         (irq)
    );

    rxd_engine #(.BUF_BYTES(BUF_BYTES), .MIN_LEN(MIN_LEN)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .kick         (kick),
        .load_cur     (load_cur),
        .load_val     (reg_wdata),
        .cur_addr     (cur_addr),
        .set_unavail  (set_unavail),
        .set_berr     (set_berr),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ack      (mem_ack),
        .mem_err      (mem_err),
        .rx_valid     (rx_valid),
        .rx_last      (rx_last),
        .rx_crc_err   (rx_crc_err),
        .rx_align_err (rx_align_err),
        .rx_ready     (rx_ready),
        .pk_clear     (pk_clear),
        .pk_push      (pk_push),
        .pk_wclr      (pk_wclr),
        .pk_word      (pk_word),
        .pk_count     (pk_count),
        .pk_over      (pk_over)
    );

    rxd_packer #(.BUF_BYTES(BUF_BYTES)) u_packer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pk_clear),
        .push    (pk_push),
        .byte_in (rx_data),
        .wclr    (pk_wclr),
        .word    (pk_word),
        .count   (pk_count),
        .over    (pk_over)
    );

endmodule

// File: tb/tb_rxdma_ring.sv
module tb_rxdma_ring;

    localparam int BUFB = 32;
    localparam int MINL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_last = 1'b0;
    logic        rx_crc_err = 1'b0;
    logic        rx_align_err = 1'b0;
    logic        rx_ready;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] mem [logic [31:0]];
    logic [63:0] exp_q [$];
    string       tag_q [$];

    rxdma_ring #(.BUF_BYTES(BUFB), .MIN_LEN(MINL)) dut (.*);

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model and scoreboard monitor, served at falling edges
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack = 1'b1;
            mem_err = (mem_addr == err_addr);
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check("R5/R6 unexpected write", mem_addr, 32'hDEAD_BEEF);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " addr"}, mem_addr, e[63:32]);
                    check({t, " data"}, mem_wdata, e[31:0]);
                end
                mem[mem_addr] = mem_wdata;
            end else begin
                mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
            end
        end else begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end
    end

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] exp_status(int len, bit crc, bit align);
        int   stored;
        logic [31:0] s;
        bit   lng, runt;
        stored = (len > BUFB) ? BUFB : len;
        lng  = len > BUFB;
        runt = stored < MINL;
        s = 32'(stored);
        if (crc)   s[17] = 1'b1;
        if (lng)   s[19] = 1'b1;
        if (align) s[21] = 1'b1;
        if (runt)  s[22] = 1'b1;
        if (!(crc || lng || align || runt)) s[20] = 1'b1;
        return s;
    endfunction

    // driver side: push the writes a frame must cause, in order
    task automatic expect_frame(input int len, input logic [7:0] seed, input bit crc,
                                input bit align, input logic [31:0] bufa,
                                input logic [31:0] desc, input string tag);
        int stored;
        stored = (len > BUFB) ? BUFB : len;
        for (int w = 0; w * 4 < stored; w++) begin
            logic [31:0] wd;
            wd = 32'd0;
            for (int b = 0; b < 4; b++) begin
                if (w * 4 + b < stored) wd[8*b +: 8] = seed + 8'(w * 4 + b);
            end
            exp_q.push_back({bufa + 32'(4 * w), wd});
            tag_q.push_back({tag, " R5 data word"});
        end
        exp_q.push_back({desc, exp_status(len, crc, align)});
        tag_q.push_back({tag, " R6/R7/R8/R9 status"});
    endtask

    task automatic drive_frame(input int len, input logic [7:0] seed, input bit crc,
                               input bit align);
        for (int k = 0; k < len; k++) begin
            rx_valid     = 1'b1;
            rx_data      = seed + 8'(k);
            rx_last      = (k == len - 1);
            rx_crc_err   = (k == len - 1) && crc;
            rx_align_err = (k == len - 1) && align;
            forever begin
                if (rx_ready) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0; rx_align_err = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n;
        n = 0;
        while (!irq && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(req, 32'(irq), 32'd1);
    endtask

    task automatic quiet_window(input string req);
        int seen;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_req || rx_ready) seen++;
        end
        check(req, 32'(seen), 32'd0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(8'h04, v); check("R1 current address", v, 32'd0);
        reg_rd(8'h0C, v); check("R1 status", v, 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 mem_req", 32'(mem_req), 32'd0);
        check("R1 rx_ready", 32'(rx_ready), 32'd0);

        // ring of three descriptors
        mem[32'h100] = 32'h8000_0000; mem[32'h104] = 32'h1000; mem[32'h10C] = 32'h110;
        mem[32'h110] = 32'h8000_0000; mem[32'h114] = 32'h2000; mem[32'h11C] = 32'h120;
        mem[32'h120] = 32'h0000_0000; mem[32'h124] = 32'h3000; mem[32'h12C] = 32'h100;

        // R2 start address load
        reg_wr(8'h00, 32'h100);
        reg_rd(8'h04, v); check("R2 current after base write", v, 32'h100);
        reg_rd(8'h00, v); check("R2 base readback", v, 32'h100);

        expect_frame(21, 8'h10, 1'b0, 1'b0, 32'h1000, 32'h100, "frameA");
        expect_frame(40, 8'h80, 1'b0, 1'b0, 32'h2000, 32'h110, "frameB R8");

        // R3 trigger: first access is a status read at the current address
        reg_wr(8'h08, 32'h1);
        while (!mem_req) @(negedge clk);
        check("R3 first access address", mem_addr, 32'h100);
        check("R3 first access is read", 32'(mem_we), 32'd0);

        drive_frame(21, 8'h10, 1'b0, 1'b0);
        drive_frame(40, 8'h80, 1'b0, 1'b0);

        // R4 software-owned descriptor stops the walk; R10 followed next pointers
        wait_irq("R4 irq on unavailable");
        reg_rd(8'h0C, v); check("R4 status bit 10", v, 32'h0000_0400);
        reg_rd(8'h04, v); check("R10 current follows next pointer", v, 32'h120);
        quiet_window("R4 no activity while stopped");
        check("R5/R6 all expected writes seen", 32'(exp_q.size()), 32'd0);

        // R12 write-one-to-clear
        reg_wr(8'h0C, 32'h0000_0400);
        reg_rd(8'h0C, v); check("R12 status cleared", v, 32'd0);
        check("R12 irq low", 32'(irq), 32'd0);

        // R7 R9 error flags and runt; then R11 bus error on the buffer address read
        mem[32'h120] = 32'h8000_0000;
        mem[32'h100] = 32'h8000_0000;
        err_addr = 32'h104;
        expect_frame(6, 8'hC0, 1'b1, 1'b1, 32'h3000, 32'h120, "frameC R7 R9");
        reg_wr(8'h08, 32'h1);
        drive_frame(6, 8'hC0, 1'b1, 1'b1);
        wait_irq("R11 irq on bus error");
        reg_rd(8'h0C, v); check("R11 status bit 11", v, 32'h0000_0800);
        reg_rd(8'h04, v); check("R11 current unchanged", v, 32'h100);
        quiet_window("R11 R13 no activity after bus error");
        check("R7 R9 all expected writes seen", 32'(exp_q.size()), 32'd0);

        reg_wr(8'h0C, 32'h0000_0800);
        check("R12 irq low after clear", 32'(irq), 32'd0);

        summary();
        $finish;
    end

endmodule